// File: doc/BRIEF.md
# Serial Host Control Port

This block is a slave-side serial port. Through it a host controller reads and writes the single 8-bit configuration register of a line interface. The host lowers an active-low select and then clocks a command byte followed by one data byte, least significant bit first in both bytes. The command byte carries a direction flag, a 6-bit device address and one bit that is don't-care. Only device address 16 is answered. A write updates the line-length, loopback and all-ones settings. Its two lowest data bits do not store anything: each produces a one-cycle request that clears a latched interrupt source. A read returns the stored settings, with the two live status flags placed in the low bits.

All serial inputs are oversampled by a free-running system clock. A static configuration input sets on which serial clock edge read data changes, and therefore how long the last read bit is held. The output has a data line and a separate drive-enable, so a pad can present it as tri-state. A flag is raised while the stored loopback/all-ones combination is one of the reserved factory-test codes.

Top module: `hcp_port`

## Requirements
- R1: A transfer opens only when the synchronised select is seen high and then low. Select held low since reset opens nothing. Select going high ends any transfer at once.
- R2: Command bit 0 is the direction (0 write, 1 read), bits 6:1 are the address and bit 7 is ignored. Only address 16 (command 8'h20 write, 8'h21 read, 8'hA1 read) has any effect. Any other address leaves `cfgReg` unchanged, keeps `sdoOe` low and produces no clear request.
- R3: A write to address 16 captures the eight data bits, taken on rising serial clock edges, least significant bit first. `cfgReg[7:2]` takes data bits 7:2 and `cfgReg[1:0]` always reads 0.
- R4: A write that ends before the 16th rising serial clock edge leaves `cfgReg` unchanged.
- R5: A committed write with data bit 0 set pulses `clrLos` for exactly one system clock. Data bit 1 does the same for `clrDpm`.
- R6: `testMode` is high exactly when `cfgReg[7:5]` is 3'b101 or 3'b111.
- R7: A read of address 16 returns `{cfgReg[7:2], dpmStatus, losStatus}` on `sdo`, least significant bit first.
- R8: With `edgeSel`=1, read bits change after falling serial clock edges. D0 follows the 8th falling edge, and the drive ends at the 16th falling edge.
- R9: With `edgeSel`=0, read bits change after rising edges. D0 follows the 9th rising edge, and D7 is driven until the 17th rising edge.
- R10: `sdoOe` drops within a few system clocks of select going high, even in the middle of a read.
- R11: After reset `cfgReg` is 0, and `sdoOe`, `clrLos`, `clrDpm` and `testMode` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in |
| edgeSel | input | 1 | Read edge select: 1 = change on falling edges, 0 = on rising edges |
| losStatus | input | 1 | Current loss-of-signal status, returned in read bit 0 |
| dpmStatus | input | 1 | Current driver-fault status, returned in read bit 1 |
| sdo | output | 1 | Serial data out, 0 when not driven |
| sdoOe | output | 1 | Drive enable for `sdo` (0 = high impedance) |
| cfgReg | output | 8 | Stored configuration, bits 1:0 always 0 |
| clrLos | output | 1 | One-cycle loss-of-signal clear request |
| clrDpm | output | 1 | One-cycle driver-fault clear request |
| testMode | output | 1 | Reserved factory-test code present in `cfgReg[7:5]` |

## Verification
Writes use data words that set each setting field in several combinations: both clear bits together, each clear bit alone, and no clear bit. The test codes 101 and 111 are separated from the legal codes 010, 011 and 100. Reads run under both edge selects and with different status-flag pairs. This shows that the low bits come from the live status and not from the written data, and it pins the cycle where the drive starts and stops for each mode. Commands with a wrong address, with the ignored top bit set, cut short mid-byte, or issued without a preceding high select tell the address decoder, the commit point and the start condition apart.

// File: rtl/hcp_pkg.sv
package hcp_pkg;
  localparam int DATA_W     = 8;
  localparam int CMD_W      = 8;
  localparam int ADDR_W     = 6;
  localparam int FRAME_BITS = CMD_W + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int OCNT_W     = $clog2(DATA_W);

  typedef enum logic [1:0] {
    OUT_IDLE,
    OUT_WAIT,
    OUT_DRIVE,
    OUT_DONE
  } outSt_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic cmdShift;
    logic dataShift;
    logic commit;
    logic outLoad;
    logic outShift;
    logic outStop;
  } hcpStrb_t;
endpackage

// File: rtl/hcp_sync.sv
module hcp_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= dIn;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dOut = stage[STAGES-1];
endmodule

// File: rtl/hcp_ctrl.sv
module hcp_ctrl
  import hcp_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     csSync,
  input  logic     sclkSync,
  input  logic     edgeSel,
  input  logic     cmdHit,
  input  logic     cmdRead,
  output hcpStrb_t strb
);
  localparam logic [CNT_W-1:0]  CMD_END   = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0]  FRAME_END = CNT_W'(FRAME_BITS);
  localparam logic [OCNT_W-1:0] OUT_LAST  = OCNT_W'(DATA_W - 1);

  logic              sclkPrev, csPrev, active;
  logic [CNT_W-1:0]  bitCnt;
  logic [OCNT_W-1:0] outCnt;
  outSt_t            outSt;
  logic              sclkRise, sclkFall, advance, live, csFall;

  always_comb begin
    sclkRise = sclkSync & ~sclkPrev;
    sclkFall = ~sclkSync & sclkPrev;
    csFall   = csPrev & ~csSync;
    advance  = edgeSel ? sclkFall : sclkRise;
    live     = active & ~csSync;

    strb.cmdShift  = live & sclkRise & (bitCnt < CMD_END);
    strb.dataShift = live & sclkRise & (bitCnt >= CMD_END) & (bitCnt < FRAME_END);
    strb.commit    = live & sclkRise & (bitCnt == FRAME_END - 1'b1) & cmdHit & ~cmdRead;
    strb.outLoad   = live & advance & (outSt == OUT_WAIT) & cmdHit & cmdRead;
    strb.outShift  = live & advance & (outSt == OUT_DRIVE) & (outCnt != OUT_LAST);
    strb.outStop   = csSync | (live & advance & (outSt == OUT_DRIVE) & (outCnt == OUT_LAST));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      csPrev   <= 1'b0;
      active   <= 1'b0;
      bitCnt   <= '0;
      outCnt   <= '0;
      outSt    <= OUT_IDLE;
    end else begin
      sclkPrev <= sclkSync;
      csPrev   <= csSync;
      if (csSync) begin
        active <= 1'b0;
        bitCnt <= '0;
        outCnt <= '0;
        outSt  <= OUT_IDLE;
      end else if (csFall) begin
        active <= 1'b1;
        bitCnt <= '0;
        outCnt <= '0;
        outSt  <= OUT_IDLE;
      end else if (active) begin
        if (sclkRise && bitCnt != FRAME_END) bitCnt <= bitCnt + 1'b1;
        unique case (outSt)
          OUT_IDLE:  if (sclkRise && bitCnt == CMD_END - 1'b1) outSt <= OUT_WAIT;
          OUT_WAIT:  if (advance) begin
                       outSt  <= (cmdHit && cmdRead) ? OUT_DRIVE : OUT_DONE;
                       outCnt <= '0;
                     end
          OUT_DRIVE: if (advance) begin
                       if (outCnt == OUT_LAST) outSt <= OUT_DONE;
                       else                    outCnt <= outCnt + 1'b1;
                     end
          OUT_DONE:  ;
          default:   outSt <= OUT_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/hcp_datapath.sv
module hcp_datapath
  import hcp_pkg::*;
#(
  parameter int DEV_ADDR = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  hcpStrb_t          strb,
  input  logic              sdiSync,
  input  logic              losStatus,
  input  logic              dpmStatus,
  output logic              cmdHit,
  output logic              cmdRead,
  output logic [DATA_W-1:0] cfgReg,
  output logic              clrLos,
  output logic              clrDpm,
  output logic              testMode,
  output logic              sdo,
  output logic              sdoOe
);
  logic [CMD_W-1:0]  cmdSh;
  logic [DATA_W-1:0] dataSh, newWord, outSh, stored;

  assign newWord = {sdiSync, dataSh[DATA_W-1:1]};
  assign cmdRead = cmdSh[0];
  assign cmdHit  = (cmdSh[ADDR_W:1] == ADDR_W'(DEV_ADDR));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdSh  <= '0;
      dataSh <= '0;
      stored <= '0;
      clrLos <= 1'b0;
      clrDpm <= 1'b0;
      outSh  <= '0;
      sdoOe  <= 1'b0;
    end else begin
      if (strb.cmdShift)  cmdSh  <= {sdiSync, cmdSh[CMD_W-1:1]};
      if (strb.dataShift) dataSh <= newWord;
      if (strb.commit)    stored <= {newWord[DATA_W-1:2], 2'b00};
      clrLos <= strb.commit & newWord[0];
      clrDpm <= strb.commit & newWord[1];
      if (strb.outLoad)       outSh <= {stored[DATA_W-1:2], dpmStatus, losStatus};
      else if (strb.outShift) outSh <= {1'b0, outSh[DATA_W-1:1]};
      if (strb.outStop)      sdoOe <= 1'b0;
      else if (strb.outLoad) sdoOe <= 1'b1;
    end
  end

  assign cfgReg   = stored;
  assign testMode = stored[7] & stored[5];
  assign sdo      = sdoOe & outSh[0];
endmodule

// File: rtl/hcp_port.sv
module hcp_port
  import hcp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEV_ADDR    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              edgeSel,
  input  logic              losStatus,
  input  logic              dpmStatus,
  output logic              sdo,
  output logic              sdoOe,
  output logic [DATA_W-1:0] cfgReg,
  output logic              clrLos,
  output logic              clrDpm,
  output logic              testMode
);
  logic     csSync, sclkSync, sdiSync, cmdHit, cmdRead;
  hcpStrb_t strb;

  // select resets low so a high level must be seen before a start
  hcp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b000)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  ({csN, sclk, sdi}),
    .dOut ({csSync, sclkSync, sdiSync})
  );

  hcp_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .csSync   (csSync),
    .sclkSync (sclkSync),
    .edgeSel  (edgeSel),
    .cmdHit   (cmdHit),
    .cmdRead  (cmdRead),
    .strb     (strb)
  );

  hcp_datapath #(.DEV_ADDR(DEV_ADDR)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .sdiSync   (sdiSync),
    .losStatus (losStatus),
    .dpmStatus (dpmStatus),
    .cmdHit    (cmdHit),
    .cmdRead   (cmdRead),
    .cfgReg    (cfgReg),
    .clrLos    (clrLos),
    .clrDpm    (clrDpm),
    .testMode  (testMode),
    .sdo       (sdo),
    .sdoOe     (sdoOe)
  );
endmodule

// File: rtl/hcp_port_chk.sv
module hcp_port_chk
  import hcp_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              csHigh,
  input logic              sdoOe,
  input logic              clrLos,
  input logic              clrDpm,
  input logic [DATA_W-1:0] cfgReg,
  input hcpStrb_t          strb
);
  p_oe_drop_r10: assert property (@(posedge clk) disable iff (!rstN)
    csHigh |=> !sdoOe);

  p_clr_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    (clrLos || clrDpm) |=> !(clrLos || clrDpm));

  p_clr_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    (clrLos || clrDpm) |-> $past(strb.commit));

  p_reg_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(cfgReg));

  p_oe_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdoOe) |-> $past(strb.outLoad));

  p_oe_end_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdoOe) |-> $past(strb.outStop));
endmodule

bind hcp_port hcp_port_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .csHigh (csSync),
  .sdoOe  (sdoOe),
  .clrLos (clrLos),
  .clrDpm (clrDpm),
  .cfgReg (cfgReg),
  .strb   (strb)
);

// File: tb/hcp_port_tb.sv
module hcp_port_tb;
  localparam int HALF  = 8;
  localparam int NVEC  = 11;

  logic clk = 1'b0;
  logic rstN, csN, sclk, sdi, edgeSel, losStatus, dpmStatus;
  logic sdo, sdoOe, clrLos, clrDpm, testMode;
  logic [7:0] cfgReg;

  int nChecks = 0;
  int nFails  = 0;
  int losCnt, dpmCnt;
  logic oeSeen;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  hcp_port u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .edgeSel(edgeSel), .losStatus(losStatus), .dpmStatus(dpmStatus),
    .sdo(sdo), .sdoOe(sdoOe), .cfgReg(cfgReg), .clrLos(clrLos),
    .clrDpm(clrDpm), .testMode(testMode)
  );

  always @(negedge clk) begin
    if (clrLos) losCnt++;
    if (clrDpm) dpmCnt++;
    if (sdoOe)  oeSeen = 1'b1;
  end

  // edge, cmd, wdata, los, dpm, expRd, expOe, expReg, expTest, expClr{dpm,los}
  localparam logic [38:0] VEC [NVEC] = '{
    {1'b1, 8'h20, 8'h5C, 1'b0, 1'b0, 8'h00, 1'b0, 8'h5C, 1'b0, 2'b00},
    {1'b1, 8'h21, 8'h00, 1'b1, 1'b0, 8'h5D, 1'b1, 8'h5C, 1'b0, 2'b00},
    {1'b0, 8'h21, 8'h00, 1'b0, 1'b1, 8'h5E, 1'b1, 8'h5C, 1'b0, 2'b00},
    {1'b1, 8'h20, 8'hA3, 1'b0, 1'b0, 8'h00, 1'b0, 8'hA0, 1'b1, 2'b11},
    {1'b0, 8'hA1, 8'h00, 1'b0, 1'b0, 8'hA0, 1'b1, 8'hA0, 1'b1, 2'b00},
    {1'b1, 8'h22, 8'hFF, 1'b0, 1'b0, 8'h00, 1'b0, 8'hA0, 1'b1, 2'b00},
    {1'b1, 8'h23, 8'h00, 1'b1, 1'b1, 8'h00, 1'b0, 8'hA0, 1'b1, 2'b00},
    {1'b0, 8'h20, 8'hE1, 1'b0, 1'b0, 8'h00, 1'b0, 8'hE0, 1'b1, 2'b01},
    {1'b0, 8'h20, 8'h62, 1'b0, 1'b0, 8'h00, 1'b0, 8'h60, 1'b0, 2'b10},
    {1'b1, 8'h20, 8'h80, 1'b1, 1'b1, 8'h00, 1'b0, 8'h80, 1'b0, 2'b00},
    {1'b0, 8'h21, 8'h00, 1'b1, 1'b1, 8'h83, 1'b1, 8'h80, 1'b0, 2'b00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one frame: select low, nBits serial clocks, optional 17th rise, select high
  task automatic frame(input logic [7:0] cmd, input logic [7:0] wdata, input int nBits,
                       input bit extra, output logic [7:0] rd, output logic oeEnd,
                       output logic oeAfter);
    rd = '0;
    oeAfter = 1'b0;
    losCnt = 0; dpmCnt = 0; oeSeen = 1'b0;
    csN = 1'b0;
    waitClk(HALF);
    for (int i = 0; i < nBits; i++) begin
      sdi = (i < 8) ? cmd[i] : wdata[i-8];
      waitClk(HALF);
      if (i >= 8 && edgeSel) rd[i-8] = sdo;
      sclk = 1'b1;
      waitClk(HALF);
      if (i >= 8 && !edgeSel) rd[i-8] = sdo;
      sclk = 1'b0;
    end
    waitClk(HALF);
    oeEnd = sdoOe;
    if (extra) begin
      sclk = 1'b1;
      waitClk(HALF);
      oeAfter = sdoOe;
      sclk = 1'b0;
      waitClk(HALF);
    end
    csN = 1'b1;
    waitClk(2*HALF);
  endtask

  initial begin
    logic [7:0] rd;
    logic oeEnd, oeAfter;
    rstN = 1'b0; csN = 1'b0; sclk = 1'b0; sdi = 1'b0;
    edgeSel = 1'b1; losStatus = 1'b0; dpmStatus = 1'b0;
    waitClk(5);
    rstN = 1'b1;
    waitClk(4);

    // R11 reset state
    chk("R11 cfgReg", cfgReg, 8'h00);
    chk("R11 sdoOe", sdoOe, 1'b0);
    chk("R11 clr", {clrDpm, clrLos}, 2'b00);
    chk("R11 testMode", testMode, 1'b0);

    // R1 select low since reset: no start, write ignored
    frame(8'h20, 8'hFC, 16, 1'b0, rd, oeEnd, oeAfter);
    chk("R1 no start without high select", cfgReg, 8'h00);
    chk("R1 no clear without start", losCnt + dpmCnt, 0);

    for (int v = 0; v < NVEC; v++) begin
      logic [38:0] e;
      e = VEC[v];
      edgeSel = e[38];
      losStatus = e[21];
      dpmStatus = e[20];
      waitClk(4);
      frame(e[37:30], e[29:22], 16, !e[38], rd, oeEnd, oeAfter);
      chk($sformatf("R3/R2 vec%0d cfgReg", v), cfgReg, e[10:3]);
      chk($sformatf("R6 vec%0d testMode", v), testMode, e[2]);
      chk($sformatf("R5 vec%0d clrLos pulses", v), losCnt, e[0]);
      chk($sformatf("R5 vec%0d clrDpm pulses", v), dpmCnt, e[1]);
      chk($sformatf("R2 vec%0d drive seen", v), oeSeen, e[11]);
      if (e[11]) begin
        chk($sformatf("R7 vec%0d read data", v), rd, e[19:12]);
        if (e[38]) chk($sformatf("R8 vec%0d off after 16th fall", v), oeEnd, 1'b0);
        else begin
          chk($sformatf("R9 vec%0d held after 16th clock", v), oeEnd, 1'b1);
          chk($sformatf("R9 vec%0d off after 17th rise", v), oeAfter, 1'b0);
        end
      end
    end

    // R4 truncated writes keep the register
    edgeSel = 1'b1;
    frame(8'h20, 8'h1C, 12, 1'b0, rd, oeEnd, oeAfter);
    chk("R4 cut after 12 bits", cfgReg, 8'h80);
    frame(8'h20, 8'hA3, 15, 1'b0, rd, oeEnd, oeAfter);
    chk("R4 cut after 15 bits", cfgReg, 8'h80);
    chk("R4 no clear on cut write", losCnt + dpmCnt, 0);

    // R10 select high in the middle of a read
    frame(8'h21, 8'h00, 11, 1'b0, rd, oeEnd, oeAfter);
    chk("R10 driving before select rise", oeEnd, 1'b1);
    chk("R10 off after select rise", sdoOe, 1'b0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule